// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock for an I2C master. It drives SCL in open-drain style: an output enable pulls the line low, and a sampled copy of the line tells the generator when the wire has actually gone high. All timing runs on an internal time base that advances once every four cycles of the input clock. The generator holds SCL low for a programmed number of time-base steps and then releases it. It waits until the line is seen high, holds the high phase for a programmed number of steps, and repeats.

The time spent waiting for the line to rise is added to each period. A slow rise, or another device holding SCL low, therefore lengthens the cycle and raises no error. A mode bit selects standard or fast timing. Fast timing shortens the active part of the period to three quarters, with roughly two thirds of it low. A single-cycle pulse marks each sampled rising edge for the byte engine, and an interrupt line follows that pulse unless it is masked.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, cfgRdData reads 0x00004000 (fast timing selected, interrupt unmasked, reference count 0), and sclOe, bitTick and irqOut are all 0.
- R2: The configuration word holds the reference count in bits 8:0, the timing mode in bit 14 (0 standard, 1 fast) and the interrupt mask in bit 15. All other bits read as zero, so writing 0xFFFFFFFF reads back 0x0000C1FF on the cycle after the write.
- R3: The generator advances only on every fourth input clock. After enable rises, sclOe asserts on the fourth rising clock edge.
- R4: In standard mode, with reference count C, sclOe stays asserted for 4*(C+2) input clocks in each low phase.
- R5: In standard mode, the spacing between consecutive bitTick pulses is 4*(2C+4+k) input clocks. Here k >= 1 is the number of time-base samples taken from the release of SCL up to and including the first sample that sees sclIn high.
- R6: In fast mode, let T = floor(3*(2C+4)/4), the high phase H = floor(T/3) steps and the low phase T-H steps. Then sclOe stays asserted for 4*(T-H) clocks, and bitTick spacing is 4*(T+k) clocks.
- R7: While sclIn stays low after release, the generator waits with no limit and emits no bitTick. The period grows by the extra wait.
- R8: When enable is low, sclOe is 0 from the next clock, no bitTick is produced, and the time base and phase restart from the beginning when enable returns.
- R9: A new reference count or mode written during a period takes effect at the next low phase. The high phase already scheduled keeps its old length.
- R10: bitTick is a one-clock pulse, issued once for each release in which sclIn is sampled high.
- R11: irqOut equals bitTick when the mask bit is 0 and stays 0 when the mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the time base is one quarter of it |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when high; releases SCL and restarts when low |
| cfgWrEn | input | 1 | Writes cfgWrData into the configuration word |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration word read-back |
| sclIn | input | 1 | Sampled level of the SCL wire |
| sclOe | output | 1 | Pulls SCL low when high |
| bitTick | output | 1 | One-clock pulse at each sampled SCL rise |
| irqOut | output | 1 | Event pulse gated by the mask bit |

## Verification
The assertions assume that sclIn, enable and the configuration port all come from the clk domain. The line is taken to change only between clock edges, so no synchronizer stage sits in front of the wait state. They also assume that nothing else pulls SCL low during a high phase once the release has been seen. The bench respects these assumptions: it updates its wire model only on falling clock edges, and lets the wire fall only while sclOe is asserted. After each release it raises the wire after a programmed number of clocks, which makes k computable as floor(delay/4)+1.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic decr;
    logic tick;
  } strobe_t;
endpackage

// File: rtl/scl_gen_dpath.sv
module scl_gen_dpath
  import scl_gen_pkg::*;
#(
  parameter int REF_W  = 9,
  parameter int CE_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  input  strobe_t     strobe,
  output logic        ce,
  output logic        cntDone,
  output logic [31:0] cfgRdData,
  output logic        bitTick,
  output logic        irqOut
);
  localparam int DIV_W = (CE_DIV > 1) ? $clog2(CE_DIV) : 1;
  localparam int CNT_W = REF_W + 3;
  localparam int MODE_BIT = 14;
  localparam int MASK_BIT = 15;

  logic [DIV_W-1:0] divCnt;
  logic [REF_W-1:0] refVal;
  logic             fastMode;
  logic             irqMask;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hiShadow;
  logic [CNT_W-1:0] base, fastTot, fastHi, fastLo, stdLen, lowLen, highLen;

  // time base: one step every CE_DIV input clocks
  always_ff @(posedge clk) begin
    if (!rstN || !enable) divCnt <= '0;
    else if (divCnt == DIV_W'(CE_DIV - 1)) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
  assign ce = enable && (divCnt == DIV_W'(CE_DIV - 1));

  // configuration word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refVal   <= '0;
      fastMode <= 1'b1;
      irqMask  <= 1'b0;
    end else if (cfgWrEn) begin
      refVal   <= cfgWrData[REF_W-1:0];
      fastMode <= cfgWrData[MODE_BIT];
      irqMask  <= cfgWrData[MASK_BIT];
    end
  end

  always_comb begin
    cfgRdData = '0;
    cfgRdData[REF_W-1:0] = refVal;
    cfgRdData[MODE_BIT]  = fastMode;
    cfgRdData[MASK_BIT]  = irqMask;
  end

  // phase lengths in time-base steps
  always_comb begin
    stdLen  = CNT_W'(refVal) + CNT_W'(2);
    base    = {CNT_W'(refVal), 1'b0} + CNT_W'(4);
    fastTot = (CNT_W'(3) * base) >> 2;
    fastHi  = fastTot / CNT_W'(3);
    fastLo  = fastTot - fastHi;
    lowLen  = fastMode ? fastLo : stdLen;
    highLen = fastMode ? fastHi : stdLen;
  end

  // phase counter; high length is frozen when a low phase begins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      hiShadow <= '0;
    end else if (strobe.loadLow) begin
      cnt      <= lowLen;
      hiShadow <= highLen;
    end else if (strobe.loadHigh) begin
      cnt <= hiShadow;
    end else if (strobe.decr) begin
      cnt <= cnt - 1'b1;
    end
  end
  assign cntDone = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) bitTick <= 1'b0;
    else bitTick <= strobe.tick;
  end
  assign irqOut = bitTick & ~irqMask;

  // R3
  ce_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    ce |=> !ce);
  // R4
  low_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLow |=> (cnt >= CNT_W'(2)));
  // R10
  tick_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);
endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    ce,
  input  logic    cntDone,
  input  logic    sclIn,
  output strobe_t strobe,
  output logic    sclOe
);
  phase_t phase, phaseNxt;

  always_comb begin
    strobe   = '0;
    phaseNxt = phase;
    case (phase)
      PH_IDLE: if (ce) begin
        strobe.loadLow = 1'b1;
        phaseNxt = PH_LOW;
      end
      PH_LOW: if (ce) begin
        if (cntDone) phaseNxt = PH_WAIT;
        else strobe.decr = 1'b1;
      end
      PH_WAIT: if (ce && sclIn) begin
        strobe.loadHigh = 1'b1;
        strobe.tick     = 1'b1;
        phaseNxt = PH_HIGH;
      end
      PH_HIGH: if (ce) begin
        if (cntDone) begin
          strobe.loadLow = 1'b1;
          phaseNxt = PH_LOW;
        end else begin
          strobe.decr = 1'b1;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) phase <= PH_IDLE;
    else phase <= phaseNxt;
  end

  assign sclOe = (phase == PH_LOW);

  // R7
  stretch_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT && !sclIn && enable) |=> (phase == PH_WAIT));
  // R8
  disable_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclOe);
  // R3
  low_on_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> $past(ce));
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int REF_W  = 9,
  parameter int CE_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        sclIn,
  output logic        sclOe,
  output logic        bitTick,
  output logic        irqOut
);
  strobe_t strobe;
  logic    ce;
  logic    cntDone;

  scl_gen_dpath #(.REF_W(REF_W), .CE_DIV(CE_DIV)) dpath_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .strobe(strobe),
    .ce(ce), .cntDone(cntDone), .cfgRdData(cfgRdData),
    .bitTick(bitTick), .irqOut(irqOut)
  );

  scl_gen_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .ce(ce),
    .cntDone(cntDone), .sclIn(sclIn), .strobe(strobe), .sclOe(sclOe)
  );
endmodule

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        sclIn;
  logic        sclOe, bitTick, irqOut;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int riseDly = 0;
  int relCnt = 1000000;

  always #4 clk = ~clk;

  scl_clock_gen dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .sclIn(sclIn),
    .sclOe(sclOe), .bitTick(bitTick), .irqOut(irqOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // open-drain wire model: falls at once, rises riseDly clocks after release
  always @(negedge clk) begin
    if (sclOe) begin
      relCnt = 0;
      sclIn  = 1'b0;
    end else begin
      relCnt = relCnt + 1;
      sclIn  = (relCnt > riseDly);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLo(input bit fast, input int c);
    int t;
    t = (3 * (2 * c + 4)) / 4;
    return fast ? (t - t / 3) : (c + 2);
  endfunction

  function automatic int expHi(input bit fast, input int c);
    int t;
    t = (3 * (2 * c + 4)) / 4;
    return fast ? (t / 3) : (c + 2);
  endfunction

  function automatic int kSamples(input int r);
    return r / 4 + 1;
  endfunction

  task automatic writeCfg(input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitTick(output int t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bitTick && n < 30000);
    if (!bitTick) check(1'b0, "R5 tick timeout", n, 0);
    t = cyc;
  endtask

  task automatic measureLow(output int len);
    int n = 0;
    while (!sclOe && n < 30000) begin
      @(negedge clk);
      n++;
    end
    len = 0;
    while (sclOe && len < 30000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic runCase(input bit fast, input int c, input int r, input string perReq);
    int t1, t2, lo, expP;
    riseDly = r;
    writeCfg({16'h0, 1'b0, fast, 5'h0, c[8:0]});
    for (int i = 0; i < 3; i++) waitTick(t1);
    waitTick(t1);
    waitTick(t2);
    expP = 4 * (expLo(fast, c) + expHi(fast, c) + kSamples(r));
    check((t2 - t1) == expP, perReq, t2 - t1, expP);
    // R11: unmasked interrupt follows the pulse
    check(irqOut == 1'b1, "R11 irq unmasked", irqOut, 1);
    @(negedge clk);
    check(bitTick == 1'b0, "R10 tick width", bitTick, 0);
    measureLow(lo);
    check(lo == 4 * expLo(fast, c), fast ? "R6 fast low" : "R4 std low", lo, 4 * expLo(fast, c));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R5 watchdog", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int t1, t2, n, ticks, irqs, expP;
    int cList[5] = '{0, 1, 2, 7, 40};
    int rList[3] = '{0, 5, 13};
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(cfgRdData == 32'h0000_4000, "R1 cfg reset", cfgRdData, 32'h4000);
    check(sclOe == 1'b0, "R1 sclOe reset", sclOe, 0);
    check(bitTick == 1'b0, "R1 bitTick reset", bitTick, 0);
    check(irqOut == 1'b0, "R1 irqOut reset", irqOut, 0);

    // R2
    writeCfg(32'hFFFF_FFFF);
    check(cfgRdData == 32'h0000_C1FF, "R2 readback", cfgRdData, 32'hC1FF);

    // R3: start latency
    @(negedge clk);
    enable = 1'b1;
    n = 0;
    while (!sclOe && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == 4, "R3 start latency", n, 4);

    // R11: masked, at C=511 fast
    ticks = 0;
    irqs = 0;
    n = 0;
    while (ticks < 3 && n < 20000) begin
      @(negedge clk);
      n++;
      if (bitTick) ticks++;
      if (irqOut) irqs++;
    end
    check(ticks == 3, "R11 masked ticks", ticks, 3);
    check(irqs == 0, "R11 masked irq", irqs, 0);
    waitTick(t1);
    waitTick(t2);
    expP = 4 * (expLo(1, 511) + expHi(1, 511) + 1);
    check((t2 - t1) == expP, "R6 fast max ref", t2 - t1, expP);

    // sweep both modes over reference counts and rise delays
    for (int m = 0; m < 2; m++)
      for (int ci = 0; ci < 5; ci++)
        for (int ri = 0; ri < 3; ri++)
          runCase(m[0], cList[ci], rList[ri], m ? "R6 fast period" : "R5 std period");
    runCase(1'b0, 511, 0, "R5 std max ref");

    // R7: long hold-off stretches the period
    runCase(1'b0, 3, 600, "R7 stretched period");
    runCase(1'b1, 3, 600, "R7 stretched fast period");

    // R9: new value applies from next low phase only
    runCase(1'b0, 3, 0, "R5 std period");
    waitTick(t1);
    writeCfg({16'h0, 1'b0, 1'b0, 5'h0, 9'd10});
    waitTick(t2);
    expP = 4 * (5 + 12 + 1);
    check((t2 - t1) == expP, "R9 deferred update", t2 - t1, expP);

    // R8: disable while driving low
    n = 0;
    while (!sclOe && n < 1000) begin
      @(negedge clk);
      n++;
    end
    enable = 1'b0;
    @(negedge clk);
    check(sclOe == 1'b0, "R8 release", sclOe, 0);
    ticks = 0;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bitTick) ticks++;
      if (sclOe) n++;
    end
    check(ticks == 0, "R8 no ticks", ticks, 0);
    check(n == 0, "R8 held released", n, 0);
    enable = 1'b1;
    n = 0;
    while (!sclOe && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == 4, "R8 restart latency", n, 4);
    measureLow(n);
    check(n == 4 * 12, "R8 R4 low after restart", n, 48);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule